// File: doc/BRIEF.md
# Lockable Watchdog Timer with Reset-Source Flag

This block is a watchdog timer with one 8-bit control register on a simple write-strobe register port. Software enables it, picks a count clock and one of four time-out lengths, and chooses the action taken on time-out. The action is either a CPU reset request held for a fixed number of cycles, or a single-cycle nonmaskable interrupt request. Once the watchdog is enabled, software cannot disable it. Only a reset clears the enable.

Software keeps the watchdog from expiring with a two-write restart sequence on a separate write-only strobe. The count clock is either the system clock or a slow tick input. The slow tick is synchronized, and each of its rising edges advances the counter by one. A sticky status bit records that a time-out happened. The external/debug reset clears that bit. The watchdog-sourced reset does not clear it. Software can therefore tell after boot which reset or interrupt source fired.

Top module: `wdog_guard`

## Requirements
- R1: After the external reset, the control register reads 0x00, `nmi_req` and `cpu_rst_req` are low, and the counter does not advance.
- R2: A register write with bit 7 set turns the watchdog on. While it is on, a write with bit 7 clear leaves bit 7 reading 1 until a reset.
- R3: Register layout: bit 7 enable, bit 6 action (1 = NMI, 0 = reset), bit 5 time-out flag, bits 4:3 clock source, bit 2 reserved, bits 1:0 period. Writes do not change bit 5. Bit 2 always reads 0.
- R4: Period code 00/01/10/11 selects a time-out of 2^EXP0/2^EXP1/2^EXP2/2^EXP3 count ticks. The defaults are 18, 22, 25 and 27. With the system clock as source, the time-out shows at the outputs exactly that many cycles after the enabling write.
- R5: With the NMI action, each time-out gives a one-cycle pulse on `nmi_req`. The counter then restarts from zero, so pulses repeat once per period.
- R6: With the reset action, each time-out raises `cpu_rst_req` for RST_HOLD (default 16) consecutive cycles. The hold runs to its end even if `rst_wdog_n` is asserted meanwhile.
- R7: Every time-out sets bit 5, under either action. `rst_wdog_n` leaves bit 5 set. `rst_ext_n` clears it.
- R8: `rst_wdog_n` clears the enable, action, clock-source and period fields.
- R9: Clock-source code 01 counts one tick per rising edge of `slow_tick`. The edge passes through a two-stage synchronizer, so a time-out shows three system cycles after the final edge is applied.
- R10: Clock-source codes 10 and 11 stop the counter, and no time-out occurs.
- R11: Two consecutive restart writes of 0xA5 and then 0x5A clear the counter. A restart write of any other value cancels an armed 0xA5 and clears nothing. A valid restart wins over a time-out in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_ext_n | input | 1 | External/debug reset, active low, clears everything |
| rst_wdog_n | input | 1 | Watchdog-sourced reset, active low, keeps the time-out flag |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| kick_wr | input | 1 | Restart write strobe |
| kick_data | input | 8 | Restart write data |
| slow_tick | input | 1 | Slow asynchronous tick used as count source 01 |
| nmi_req | output | 1 | One-cycle nonmaskable interrupt request |
| cpu_rst_req | output | 1 | Stretched CPU reset request |

## Verification
The counter runs from the system clock with each of the four period codes. It also runs from a slow tick made of separate pulses, which shows that only synchronized rising edges count, not cycles. Three restart patterns are applied. The valid pair must push the time-out out by a full period, and a pair broken by a foreign value must leave the original deadline in place. The two actions are run back to back. Reset pulses on each reset input then separate the flag, which survives the watchdog reset, from the fields that do not survive it.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   typedef enum logic [1:0] {
      SRC_SYS  = 2'b00,
      SRC_SLOW = 2'b01,
      SRC_RSV2 = 2'b10,
      SRC_RSV3 = 2'b11
   } wdog_src_e;

   typedef struct packed {
      logic      on;
      logic      act_nmi;
      wdog_src_e src;
      logic [1:0] per;
   } wdog_ctl_t;

   localparam int unsigned POS_ON   = 7;
   localparam int unsigned POS_ACT  = 6;
   localparam int unsigned POS_SRC  = 3;
   localparam int unsigned POS_PER  = 0;

   function automatic wdog_ctl_t ctl_decode(input logic [7:0] b);
      wdog_ctl_t c;
      c.on      = b[POS_ON];
      c.act_nmi = b[POS_ACT];
      c.src     = wdog_src_e'(b[POS_SRC +: 2]);
      c.per     = b[POS_PER +: 2];
      return c;
   endfunction

endpackage

// File: rtl/wdog_tick_sync.sv
module wdog_tick_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_in,
   output logic tick_rise
);
   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[gi] <= 1'b0;
               else        sync_q[gi] <= tick_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[gi] <= 1'b0;
               else        sync_q[gi] <= sync_q[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[STAGES-1];
   end

   assign tick_rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/wdog_kick_seq.sv
module wdog_kick_seq #(
   parameter logic [7:0] ARM_VAL  = 8'hA5,
   parameter logic [7:0] FIRE_VAL = 8'h5A
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       kick_wr,
   input  logic [7:0] kick_data,
   output logic       kick_clr
);
   logic armed_q;

   assign kick_clr = kick_wr & armed_q & (kick_data == FIRE_VAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       armed_q <= 1'b0;
      else if (kick_wr) armed_q <= (kick_data == ARM_VAL);
   end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int unsigned EXP0 = 18,
   parameter int unsigned EXP1 = 22,
   parameter int unsigned EXP2 = 25,
   parameter int unsigned EXP3 = 27,
   localparam int unsigned CNT_W = EXP3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       clr,
   input  logic [1:0] per,
   output logic       fire
);
   localparam logic [CNT_W-1:0] TERM0 = CNT_W'((64'd1 << EXP0) - 64'd1);
   localparam logic [CNT_W-1:0] TERM1 = CNT_W'((64'd1 << EXP1) - 64'd1);
   localparam logic [CNT_W-1:0] TERM2 = CNT_W'((64'd1 << EXP2) - 64'd1);
   localparam logic [CNT_W-1:0] TERM3 = CNT_W'((64'd1 << EXP3) - 64'd1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] term;

   always_comb begin
      unique case (per)
         2'd0:    term = TERM0;
         2'd1:    term = TERM1;
         2'd2:    term = TERM2;
         default: term = TERM3;
      endcase
   end

   assign fire = run & ~clr & (cnt_q == term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_q <= '0;
      else if (clr || fire) cnt_q <= '0;
      else if (run)         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
   import wdog_pkg::*;
#(
   parameter int unsigned EXP0        = 18,
   parameter int unsigned EXP1        = 22,
   parameter int unsigned EXP2        = 25,
   parameter int unsigned EXP3        = 27,
   parameter int unsigned RST_HOLD    = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [7:0]  KICK_ARM    = 8'hA5,
   parameter logic [7:0]  KICK_FIRE   = 8'h5A
) (
   input  logic       clk,
   input  logic       rst_ext_n,
   input  logic       rst_wdog_n,
   input  logic       reg_wr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       kick_wr,
   input  logic [7:0] kick_data,
   input  logic       slow_tick,
   output logic       nmi_req,
   output logic       cpu_rst_req
);
   localparam int unsigned HOLD_W = $clog2(RST_HOLD + 1);

   generate
      if (EXP0 < 1 || !(EXP0 < EXP1 && EXP1 < EXP2 && EXP2 < EXP3) || EXP3 > 32)
      begin : g_bad_exp
         $error("wdog_guard: period exponents must rise strictly and stay within 1..32");
      end
      if (RST_HOLD < 1 || (64'd1 << EXP0) < 64'(RST_HOLD)) begin : g_bad_hold
         $error("wdog_guard: RST_HOLD must be at least 1 and no longer than the shortest period");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("wdog_guard: SYNC_STAGES must be at least 2");
      end
      if (KICK_ARM == KICK_FIRE) begin : g_bad_kick
         $error("wdog_guard: restart values must differ");
      end
   endgenerate

   logic rst_any_n;
   assign rst_any_n = rst_ext_n & rst_wdog_n;

   wdog_ctl_t ctl_q;
   wdog_ctl_t ctl_wr;
   logic      flag_q;
   logic      nmi_q;
   logic [HOLD_W-1:0] hold_q;
   logic      tick_rise;
   logic      kick_clr;
   logic      tick_ok;
   logic      run;
   logic      fire;

   assign ctl_wr = ctl_decode(reg_wdata);

   always_ff @(posedge clk or negedge rst_any_n) begin
      if (!rst_any_n) begin
         ctl_q <= '{on: 1'b0, act_nmi: 1'b0, src: SRC_SYS, per: 2'b00};
      end else if (reg_wr) begin
         ctl_q.on      <= ctl_q.on | ctl_wr.on;
         ctl_q.act_nmi <= ctl_wr.act_nmi;
         ctl_q.src     <= ctl_wr.src;
         ctl_q.per     <= ctl_wr.per;
      end
   end

   wdog_tick_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk       (clk),
      .rst_n     (rst_any_n),
      .tick_in   (slow_tick),
      .tick_rise (tick_rise)
   );

   wdog_kick_seq #(.ARM_VAL(KICK_ARM), .FIRE_VAL(KICK_FIRE)) i_kick (
      .clk       (clk),
      .rst_n     (rst_any_n),
      .kick_wr   (kick_wr),
      .kick_data (kick_data),
      .kick_clr  (kick_clr)
   );

   always_comb begin
      unique case (ctl_q.src)
         SRC_SYS:  tick_ok = 1'b1;
         SRC_SLOW: tick_ok = tick_rise;
         default:  tick_ok = 1'b0;
      endcase
   end

   assign run = ctl_q.on & tick_ok;

   wdog_counter #(.EXP0(EXP0), .EXP1(EXP1), .EXP2(EXP2), .EXP3(EXP3)) i_cnt (
      .clk   (clk),
      .rst_n (rst_any_n),
      .run   (run),
      .clr   (kick_clr),
      .per   (ctl_q.per),
      .fire  (fire)
   );

   always_ff @(posedge clk or negedge rst_ext_n) begin
      if (!rst_ext_n) flag_q <= 1'b0;
      else if (fire)  flag_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_any_n) begin
      if (!rst_any_n) nmi_q <= 1'b0;
      else            nmi_q <= fire & ctl_q.act_nmi;
   end

   always_ff @(posedge clk or negedge rst_ext_n) begin
      if (!rst_ext_n)                  hold_q <= '0;
      else if (fire && !ctl_q.act_nmi) hold_q <= HOLD_W'(RST_HOLD);
      else if (hold_q != '0)           hold_q <= hold_q - 1'b1;
   end

   assign nmi_req     = nmi_q;
   assign cpu_rst_req = (hold_q != '0);
   assign reg_rdata   = {ctl_q.on, ctl_q.act_nmi, flag_q, ctl_q.src, 1'b0, ctl_q.per};
endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk (
   input logic       clk,
   input logic       rst_ext_n,
   input logic       rst_wdog_n,
   input logic [7:0] reg_rdata,
   input logic       nmi_req,
   input logic       cpu_rst_req
);
   p_enable_locked_r2: assert property (@(posedge clk) disable iff (!rst_ext_n || !rst_wdog_n)
      reg_rdata[7] |=> reg_rdata[7]);

   p_bit2_zero_r3: assert property (@(posedge clk) disable iff (!rst_ext_n)
      !reg_rdata[2]);

   p_nmi_single_r5: assert property (@(posedge clk) disable iff (!rst_ext_n || !rst_wdog_n)
      nmi_req |=> !nmi_req);

   p_hold_continues_r6: assert property (@(posedge clk) disable iff (!rst_ext_n)
      $rose(cpu_rst_req) |=> cpu_rst_req);

   p_flag_with_nmi_r7: assert property (@(posedge clk) disable iff (!rst_ext_n)
      nmi_req |-> reg_rdata[5]);

   p_one_action_r5: assert property (@(posedge clk) disable iff (!rst_ext_n)
      nmi_req |-> !$rose(cpu_rst_req));

   p_reserved_src_stops_r10: assert property (@(posedge clk) disable iff (!rst_ext_n || !rst_wdog_n)
      reg_rdata[4] |=> (!nmi_req && !$rose(cpu_rst_req)));
endmodule

bind wdog_guard wdog_guard_chk i_chk (
   .clk         (clk),
   .rst_ext_n   (rst_ext_n),
   .rst_wdog_n  (rst_wdog_n),
   .reg_rdata   (reg_rdata),
   .nmi_req     (nmi_req),
   .cpu_rst_req (cpu_rst_req)
);

// File: tb/test_wdog_guard.sv
module test_wdog_guard;
   localparam int unsigned E0 = 5;
   localparam int unsigned E1 = 6;
   localparam int unsigned E2 = 8;
   localparam int unsigned E3 = 10;
   localparam int unsigned HOLD = 16;

   logic       clk = 1'b0;
   logic       rst_ext_n = 1'b0;
   logic       rst_wdog_n = 1'b1;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       kick_wr = 1'b0;
   logic [7:0] kick_data = 8'h00;
   logic       slow_tick = 1'b0;
   logic       nmi_req;
   logic       cpu_rst_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   longint cyc = 0;

   typedef struct {
      bit     is_rst;
      longint at;
   } ev_t;
   ev_t exp_q[$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wdog_guard #(.EXP0(E0), .EXP1(E1), .EXP2(E2), .EXP3(E3), .RST_HOLD(HOLD)) i_wdog_guard (
      .clk(clk), .rst_ext_n(rst_ext_n), .rst_wdog_n(rst_wdog_n),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .kick_wr(kick_wr), .kick_data(kick_data), .slow_tick(slow_tick),
      .nmi_req(nmi_req), .cpu_rst_req(cpu_rst_req)
   );

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   task automatic push(input bit is_rst, input longint at);
      ev_t e;
      e.is_rst = is_rst;
      e.at = at;
      exp_q.push_back(e);
   endtask

   // Monitor: pops the expected time-out events and checks their kind and cycle.
   bit     rst_prev = 1'b0;
   int     hold_len = 0;
   always @(negedge clk) begin
      if (rst_ext_n) begin
         if (nmi_req || (cpu_rst_req && !rst_prev)) begin
            if (exp_q.size() == 0) begin
               check(cpu_rst_req ? "R6 unexpected reset request" : "R5 unexpected NMI",
                     cyc, -1);
            end else begin
               ev_t e;
               e = exp_q.pop_front();
               check("R4 time-out kind", cpu_rst_req && !rst_prev, e.is_rst);
               check("R4 time-out cycle", cyc, e.at);
            end
         end
         if (cpu_rst_req) hold_len++;
         else if (rst_prev) begin
            check("R6 reset request width", hold_len, HOLD);
            hold_len = 0;
         end
      end
      rst_prev = cpu_rst_req;
   end

   task automatic wr(input logic [7:0] v);
      reg_wr = 1'b1;
      reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic kick(input logic [7:0] v);
      kick_wr = 1'b1;
      kick_data = v;
      @(negedge clk);
      kick_wr = 1'b0;
   endtask

   task automatic wait_until(input longint c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic ext_reset();
      rst_ext_n = 1'b0;
      @(negedge clk);
      rst_ext_n = 1'b1;
      @(negedge clk);
      check("R1 queue drained before reset", exp_q.size(), 0);
      check("R1 register after external reset", reg_rdata, 8'h00);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      longint t;
      longint tk;
      repeat (3) @(negedge clk);
      rst_ext_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 register reset", reg_rdata, 8'h00);
      check("R1 nmi low", nmi_req, 0);
      check("R1 reset request low", cpu_rst_req, 0);
      repeat (80) @(negedge clk);   // disabled: monitor flags any event

      // R4/R5/R7 NMI action, system clock, shortest period
      wr(8'hC0);
      t = cyc;
      push(0, t + (1 << E0));
      push(0, t + 2 * (1 << E0));
      wait_until(t + (1 << E0) + 1);
      check("R7 flag after NMI time-out", reg_rdata, 8'hE0);
      wr(8'h40);
      check("R2 enable stays set", reg_rdata, 8'hE0);
      wr(8'h64);
      check("R3 flag and reserved bit not writable", reg_rdata, 8'hE0);
      wait_until(t + 2 * (1 << E0) + 1);
      check("R5 periodic NMI delivered", exp_q.size(), 0);
      // R10 reserved clock source stops counting
      wr(8'h50);
      check("R10 register with reserved source", reg_rdata, 8'hF0);
      repeat (200) @(negedge clk);
      wr(8'h58);
      repeat (200) @(negedge clk);
      ext_reset();

      // R11 restart sequence
      wr(8'hC1);
      repeat (40) @(negedge clk);
      kick(8'hA5);
      kick(8'h5A);
      tk = cyc;
      push(0, tk + (1 << E1));
      repeat (30) @(negedge clk);
      kick(8'hA5);
      kick(8'h11);
      kick(8'h5A);
      wait_until(tk + (1 << E1) + 1);
      check("R11 valid restart delayed, broken one ignored", exp_q.size(), 0);
      wr(8'h51);
      repeat (100) @(negedge clk);
      ext_reset();

      // R4 longer periods
      for (int sel = 2; sel < 4; sel++) begin
         longint lim;
         lim = (sel == 2) ? (1 << E2) : (1 << E3);
         wr(8'hC0 | 8'(sel));
         t = cyc;
         push(0, t + lim);
         wait_until(t + lim + 1);
         check("R4 period code delivered", exp_q.size(), 0);
         wr(8'h50 | 8'(sel));
         repeat (20) @(negedge clk);
         ext_reset();
      end

      // R9 slow tick source, one count per rising edge
      wr(8'hC8);
      for (int p = 1; p <= (1 << E0); p++) begin
         if (p == (1 << E0)) push(0, cyc + 3);
         slow_tick = 1'b1;
         repeat (2) @(negedge clk);
         slow_tick = 1'b0;
         repeat (2) @(negedge clk);
      end
      repeat (40) @(negedge clk);
      check("R9 slow tick time-out seen", exp_q.size(), 0);
      check("R9 register after slow time-out", reg_rdata, 8'hE8);
      ext_reset();

      // R6/R7/R8 reset action and the two reset inputs
      wr(8'h80);
      t = cyc;
      push(1, t + (1 << E0));
      wait_until(t + (1 << E0) + 2);
      rst_wdog_n = 1'b0;
      @(negedge clk);
      rst_wdog_n = 1'b1;
      check("R8 watchdog reset clears enable, R7 keeps flag", reg_rdata, 8'h20);
      check("R6 reset request still held", cpu_rst_req, 1);
      repeat (60) @(negedge clk);
      check("R6 reset request delivered", exp_q.size(), 0);
      rst_ext_n = 1'b0;
      @(negedge clk);
      rst_ext_n = 1'b1;
      @(negedge clk);
      check("R7 external reset clears flag", reg_rdata, 8'h00);

      check("R5 no leftover expected events", exp_q.size(), 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule